// File: doc/BRIEF.md
# Multichannel Audio Playback Sample FIFO

This block buffers outgoing audio samples between a processor and a serial audio transmitter. Software writes samples one channel word at a time through a small register window. The transmitter pulls words one at a time with a pop strobe. Each word carries 24 significant bits. A 16-bit sample is placed left-aligned in bits 23:8.

The storage holds 256 words shifted left by a 3-bit size parameter. Space is handed out per frame, in channel units rounded up to a power of two. As a result, three channels get the same frame depth as four, and five to seven get the same depth as eight. The part of the storage that is left over stays unused.

A status word reports the number of complete frames waiting, together with two sticky error flags. A control word holds a one-shot clear command and an enable for a level-sensitive request. That request is raised while the buffer has drained to half of its frame capacity or below.

Top module: `audio_tx_fifo`

## Requirements
- R1: The frame capacity is (256 << SIZE_CODE) >> s, where s is the smallest integer with 2^s >= `cfg_chans`. Data writes are accepted until capacity × `cfg_chans` words are held.
- R2: Status bits 16:8 give the level. The level is the number of complete frames written minus the number of complete frames popped, where a frame is `cfg_chans` consecutive words.
- R3: A data write (address 2) made while the buffer is full is discarded. It leaves the level unchanged and sets the sticky overrun flag at status bit 4.
- R4: A pop made while the buffer is empty loads zero into `ser_data` and sets the sticky underrun flag at status bit 0.
- R5: A status write (address 1) clears each flag whose bit is written as 0, so writing zero clears both flags. A flag whose bit is written as 1 keeps its value.
- R6: Only bits 23:0 of a data write are stored. Reading address 2 returns the oldest stored word in bits 23:0, with bits 31:24 reading as zero. When the buffer is empty, the read returns zero.
- R7: Popped words leave in write order. Each word appears on `ser_data` in the cycle after its pop and is held there until the next pop.
- R8: Writing 1 to control bit 0 (address 0) makes that bit read 1 for exactly one cycle. The buffer is empty from the cycle after that. The error flags are not changed by the clear.
- R9: `irq_half` is high exactly while control bit 20 is set and the level is at most half of the frame capacity.
- R10: After reset, the control word, the status word, `irq_half` and `ser_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_chans | input | CH_W | Channels per frame, 1 to 8 |
| cpu_we | input | 1 | Register write strobe |
| cpu_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| cpu_wdata | input | 32 | Register write data |
| cpu_rdata | output | 32 | Read data for the selected register |
| ser_pop | input | 1 | Transmitter pop strobe |
| ser_data | output | 24 | Word returned by the most recent pop |
| irq_half | output | 1 | Half-level request |

## Verification
Register reads are combinational. Status and data readback therefore reflect a write in the cycle right after the edge that took it, and the bench reads at the falling edge that follows each write. `ser_data` is registered and is sampled one cycle after the pop strobe. The clear command shows its pending bit in the first cycle after the write and the empty level in the second, and the bench checks both of those cycles. `irq_half` is compared after every single write and pop against a level that the bench computes by integer division of its own word counts.

// File: rtl/atf_pkg.sv
package atf_pkg;
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_DATA = 2'd2
  } atf_reg_e;

  localparam int CTRL_CLR_BIT  = 0;
  localparam int CTRL_HALF_BIT = 20;
  localparam int STAT_UND_BIT  = 0;
  localparam int STAT_OVR_BIT  = 4;
  localparam int STAT_LVL_W    = 9;
  localparam int SAMPLE_W      = 24;
endpackage

// File: rtl/atf_capacity.sv
module atf_capacity #(
  parameter int BASE_WORDS = 256,
  parameter int CH_W       = 4,
  parameter int FRM_W      = 9
) (
  input  logic [CH_W-1:0]  chans,
  output logic [FRM_W-1:0] cap_frames,
  output logic [FRM_W-1:0] cap_words
);
  localparam int SH_W = $clog2(CH_W + 1);

  logic [SH_W-1:0] sh;

  // smallest power of two that covers the channel count
  always_comb begin
    sh = '0;
    for (int i = 0; i < CH_W; i++) begin
      if ((32'd1 << i) < 32'(chans)) sh = SH_W'(i + 1);
    end
    cap_frames = FRM_W'(BASE_WORDS) >> sh;
    cap_words  = FRM_W'(cap_frames * FRM_W'(chans));
  end
endmodule

// File: rtl/atf_store.sv
module atf_store #(
  parameter int BASE_WORDS = 256,
  parameter int DW         = 24,
  parameter int CNT_W      = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic [DW-1:0]    wdata,
  input  logic             pop,
  input  logic [CNT_W-1:0] cap_words,
  output logic [DW-1:0]    head,
  output logic [DW-1:0]    rdata,
  output logic [CNT_W-1:0] word_cnt,
  output logic             full,
  output logic             empty,
  output logic             push_ok,
  output logic             pop_ok
);
  localparam int PTR_W = $clog2(BASE_WORDS);

  logic [DW-1:0]    mem [BASE_WORDS];
  logic [PTR_W-1:0] wr_ptr, wr_ptr_d, rd_ptr, rd_ptr_d;
  logic [CNT_W-1:0] cnt_d;
  logic [DW-1:0]    rdata_d;

  assign full    = (word_cnt >= cap_words);
  assign empty   = (word_cnt == '0);
  assign push_ok = push & ~full & ~clr;
  assign pop_ok  = pop & ~empty;
  assign head    = mem[rd_ptr];

  always_comb begin
    wr_ptr_d = wr_ptr;
    rd_ptr_d = rd_ptr;
    cnt_d    = word_cnt;
    rdata_d  = rdata;
    if (pop) rdata_d = pop_ok ? head : '0;
    if (clr) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      cnt_d    = '0;
    end else begin
      if (push_ok) wr_ptr_d = wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr_d = rd_ptr + 1'b1;
      cnt_d = word_cnt + CNT_W'(push_ok) - CNT_W'(pop_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      word_cnt <= '0;
      rdata    <= '0;
    end else begin
      wr_ptr   <= wr_ptr_d;
      rd_ptr   <= rd_ptr_d;
      word_cnt <= cnt_d;
      rdata    <= rdata_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end
endmodule

// File: rtl/atf_frame_count.sv
module atf_frame_count #(
  parameter int CH_W  = 4,
  parameter int FRM_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [CH_W-1:0]  chans,
  input  logic             push_ok,
  input  logic             pop_ok,
  output logic [FRM_W-1:0] frame_lvl
);
  logic [CH_W-1:0]  wr_slot, wr_slot_d, rd_slot, rd_slot_d, last;
  logic             wr_wrap, rd_wrap;
  logic [FRM_W-1:0] lvl_d;

  assign last    = chans - CH_W'(1);
  assign wr_wrap = push_ok && (wr_slot == last);
  assign rd_wrap = pop_ok && (rd_slot == last);

  always_comb begin
    wr_slot_d = wr_slot;
    rd_slot_d = rd_slot;
    lvl_d     = frame_lvl;
    if (clr) begin
      wr_slot_d = '0;
      rd_slot_d = '0;
      lvl_d     = '0;
    end else begin
      if (push_ok) wr_slot_d = wr_wrap ? '0 : wr_slot + 1'b1;
      if (pop_ok)  rd_slot_d = rd_wrap ? '0 : rd_slot + 1'b1;
      lvl_d = frame_lvl + FRM_W'(wr_wrap) - FRM_W'(rd_wrap);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_slot   <= '0;
      rd_slot   <= '0;
      frame_lvl <= '0;
    end else begin
      wr_slot   <= wr_slot_d;
      rd_slot   <= rd_slot_d;
      frame_lvl <= lvl_d;
    end
  end
endmodule

// File: rtl/audio_tx_fifo.sv
module audio_tx_fifo
  import atf_pkg::*;
#(
  parameter int SIZE_CODE = 0,
  parameter int CH_W      = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CH_W-1:0]     cfg_chans,
  input  logic                cpu_we,
  input  logic [1:0]          cpu_addr,
  input  logic [31:0]         cpu_wdata,
  output logic [31:0]         cpu_rdata,
  input  logic                ser_pop,
  output logic [SAMPLE_W-1:0] ser_data,
  output logic                irq_half
);
  localparam int BASE_WORDS = 256 << SIZE_CODE;
  localparam int FRM_W      = $clog2(BASE_WORDS) + 1;

  logic [1:0]            rst_pipe;
  logic                  rst_ni;
  logic                  half_en_q, half_en_d, clr_q, clr_d;
  logic                  ovr_q, ovr_d, und_q, und_d;
  logic                  wr_ctrl, wr_stat, wr_data;
  logic                  full, empty, push_ok, pop_ok;
  logic [FRM_W-1:0]      cap_frames, cap_words, word_cnt, frame_lvl;
  logic [SAMPLE_W-1:0]   head;
  logic [STAT_LVL_W-1:0] lvl_field;
  logic                  unused_hi;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  assign wr_ctrl   = cpu_we && (cpu_addr == REG_CTRL);
  assign wr_stat   = cpu_we && (cpu_addr == REG_STAT);
  assign wr_data   = cpu_we && (cpu_addr == REG_DATA);
  assign unused_hi = ^cpu_wdata[31:24];

  atf_capacity #(.BASE_WORDS(BASE_WORDS), .CH_W(CH_W), .FRM_W(FRM_W)) u_cap (
    .chans(cfg_chans), .cap_frames(cap_frames), .cap_words(cap_words)
  );

  atf_store #(.BASE_WORDS(BASE_WORDS), .DW(SAMPLE_W), .CNT_W(FRM_W)) u_store (
    .clk(clk), .rst_n(rst_ni), .clr(clr_q), .push(wr_data),
    .wdata(cpu_wdata[SAMPLE_W-1:0]), .pop(ser_pop), .cap_words(cap_words),
    .head(head), .rdata(ser_data), .word_cnt(word_cnt), .full(full),
    .empty(empty), .push_ok(push_ok), .pop_ok(pop_ok)
  );

  atf_frame_count #(.CH_W(CH_W), .FRM_W(FRM_W)) u_frames (
    .clk(clk), .rst_n(rst_ni), .clr(clr_q), .chans(cfg_chans),
    .push_ok(push_ok), .pop_ok(pop_ok), .frame_lvl(frame_lvl)
  );

  generate
    if (FRM_W <= STAT_LVL_W) begin : g_lvl_fit
      assign lvl_field = STAT_LVL_W'(frame_lvl);
    end else begin : g_lvl_sat
      assign lvl_field = (frame_lvl > FRM_W'(2**STAT_LVL_W - 1)) ? '1
                                                              : frame_lvl[STAT_LVL_W-1:0];
    end
  endgenerate

  always_comb begin
    half_en_d = wr_ctrl ? cpu_wdata[CTRL_HALF_BIT] : half_en_q;
    clr_d     = wr_ctrl && cpu_wdata[CTRL_CLR_BIT];
    ovr_d     = (wr_data && full) ||
                (ovr_q && (!wr_stat || cpu_wdata[STAT_OVR_BIT]));
    und_d     = (ser_pop && empty) ||
                (und_q && (!wr_stat || cpu_wdata[STAT_UND_BIT]));
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      half_en_q <= 1'b0;
      clr_q     <= 1'b0;
      ovr_q     <= 1'b0;
      und_q     <= 1'b0;
    end else begin
      half_en_q <= half_en_d;
      clr_q     <= clr_d;
      ovr_q     <= ovr_d;
      und_q     <= und_d;
    end
  end

  assign irq_half = half_en_q && (frame_lvl <= (cap_frames >> 1));

  always_comb begin
    case (cpu_addr)
      REG_CTRL: cpu_rdata = {11'd0, half_en_q, 19'd0, clr_q};
      REG_STAT: cpu_rdata = {15'd0, lvl_field, 3'd0, ovr_q, 3'd0, und_q};
      REG_DATA: cpu_rdata = {8'd0, empty ? {SAMPLE_W{1'b0}} : head};
      default:  cpu_rdata = '0;
    endcase
  end
endmodule

// File: rtl/audio_tx_fifo_chk.sv
module audio_tx_fifo_chk #(
  parameter int FRM_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_we,
  input logic [1:0]       cpu_addr,
  input logic             wd_clr,
  input logic [7:0]       rd_top,
  input logic             ser_pop,
  input logic [23:0]      ser_data,
  input logic             irq_half,
  input logic             half_en_q,
  input logic             clr_q,
  input logic             ovr_q,
  input logic             und_q,
  input logic             full,
  input logic             empty,
  input logic [FRM_W-1:0] word_cnt,
  input logic [FRM_W-1:0] frame_lvl,
  input logic [FRM_W-1:0] cap_words
);
  // R1
  words_within_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_cnt <= cap_words);

  // R3
  drop_on_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && cpu_addr == 2'd2 && full && !ser_pop && !clr_q)
    |=> ($stable(word_cnt) && ovr_q));

  // R4
  underrun_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_pop && empty) |=> (ser_data == 24'd0 && und_q));

  // R5
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !(cpu_we && cpu_addr == 2'd1)) |=> ovr_q);

  // R6
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_top == 8'd0);

  // R8
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_q |=> (word_cnt == '0 && frame_lvl == '0));

  // R8
  clear_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_q && !(cpu_we && cpu_addr == 2'd0 && wd_clr)) |=> !clr_q);

  // R9
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !half_en_q |-> !irq_half);
endmodule

bind audio_tx_fifo audio_tx_fifo_chk #(.FRM_W(FRM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
  .wd_clr(cpu_wdata[0]), .rd_top(cpu_rdata[31:24]), .ser_pop(ser_pop),
  .ser_data(ser_data), .irq_half(irq_half), .half_en_q(half_en_q),
  .clr_q(clr_q), .ovr_q(ovr_q), .und_q(und_q), .full(full), .empty(empty),
  .word_cnt(word_cnt), .frame_lvl(frame_lvl), .cap_words(cap_words)
);

// File: tb/tb_audio_tx_fifo.sv
`timescale 1ns/1ps
module tb_audio_tx_fifo;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cfg_chans = 4'd1;
  logic        cpu_we = 1'b0;
  logic [1:0]  cpu_addr = 2'd0;
  logic [31:0] cpu_wdata = 32'd0;
  logic [31:0] cpu_rdata;
  logic        ser_pop = 1'b0;
  logic [23:0] ser_data;
  logic        irq_half;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  audio_tx_fifo dut (
    .clk(clk), .rst_n(rst_n), .cfg_chans(cfg_chans), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .ser_pop(ser_pop), .ser_data(ser_data), .irq_half(irq_half)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
    cpu_addr = a;
    #1;
    d = cpu_rdata;
  endtask

  task automatic do_pop();
    @(negedge clk);
    ser_pop = 1'b1;
    @(negedge clk);
    ser_pop = 1'b0;
  endtask

  function automatic logic [31:0] sample(input int i, input int ch);
    return {8'hA5 ^ 8'(i), 4'(ch), 20'(i * 37 + 5)};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10 reset state
    reg_rd(2'd0, rd); check("R10 ctrl", rd, 32'd0);
    reg_rd(2'd1, rd); check("R10 status", rd, 32'd0);
    check("R10 irq", {31'd0, irq_half}, 32'd0);
    check("R10 ser_data", {8'd0, ser_data}, 32'd0);

    for (int ch = 1; ch <= 8; ch++) begin
      int s, capf, capw, w, r;
      s = 0;
      while ((1 << s) < ch) s++;
      capf = 256 >> s;
      capw = capf * ch;
      cfg_chans = 4'(ch);
      // R8 clear with half-level enable
      reg_wr(2'd0, 32'h0010_0001);
      reg_rd(2'd0, rd); check("R8 clear bit pending", rd, 32'h0010_0001);
      @(negedge clk);
      reg_rd(2'd0, rd); check("R8 clear bit self-clears", rd, 32'h0010_0000);
      reg_rd(2'd1, rd); check("R8 empty after clear", rd, 32'd0);
      check("R9 irq at empty", {31'd0, irq_half}, 32'd1);
      w = 0; r = 0;
      for (int i = 0; i < capw; i++) begin
        reg_wr(2'd2, sample(i, ch));
        w++;
        reg_rd(2'd1, rd); check("R2 level on fill", rd, 32'((w / ch) << 8));
        check("R9 irq on fill", {31'd0, irq_half}, 32'((w / ch) <= capf / 2));
      end
      // R1 capacity reached: next write overruns, R3
      reg_wr(2'd2, 32'h00FF_FFFF);
      reg_rd(2'd1, rd); check("R3 overrun at capacity (R1)", rd, 32'((capf << 8) | 16));
      reg_rd(2'd2, rd); check("R6 data readback", rd, sample(0, ch) & 32'h00FF_FFFF);
      reg_wr(2'd1, 32'h0000_0010);
      reg_rd(2'd1, rd); check("R5 flag kept by 1", rd, 32'((capf << 8) | 16));
      reg_wr(2'd1, 32'h0000_0000);
      reg_rd(2'd1, rd); check("R5 flag cleared by 0", rd, 32'(capf << 8));
      for (int j = 0; j < capw; j++) begin
        do_pop();
        r++;
        check("R7 pop order", {8'd0, ser_data}, sample(j, ch) & 32'h00FF_FFFF);
        reg_rd(2'd1, rd); check("R2 level on drain", rd, 32'(((w / ch) - (r / ch)) << 8));
        check("R9 irq on drain", {31'd0, irq_half}, 32'(((w / ch) - (r / ch)) <= capf / 2));
      end
      do_pop();
      check("R4 underrun data", {8'd0, ser_data}, 32'd0);
      reg_rd(2'd1, rd); check("R4 underrun flag", rd, 32'd1);
      reg_rd(2'd2, rd); check("R6 empty data read", rd, 32'd0);
      // R8 clear keeps flags; R9 disabled request
      reg_wr(2'd0, 32'h0000_0001);
      @(negedge clk);
      reg_rd(2'd1, rd); check("R8 clear keeps flags", rd, 32'd1);
      check("R9 irq disabled", {31'd0, irq_half}, 32'd0);
      reg_wr(2'd1, 32'd0);
      reg_rd(2'd1, rd); check("R5 underrun cleared", rd, 32'd0);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule